// File: doc/BRIEF.md
# Serial Control Register Slave for an A/V Routing Switch

This block is the two-wire serial slave that holds the control register bank of an audio/video routing switch. A host writes the bank by sending the device address with the write direction, a one-byte register pointer, and then one or more data bytes. The pointer advances by one after every data byte, so a whole bank can be loaded in one transfer. A host read returns one status byte taken from a monitor block, with no pointer phase. When the status byte has been shifted out, the slave gives the monitor a one-cycle clear strobe. The monitor uses this strobe to drop its change flag.

SCL and SDA are oversampled by the system clock through a two-flop synchronizer. START and STOP are recognised as SDA edges while SCL is high. The slave pulls SDA low through an output enable and never drives it high. All seven registers are presented together on one flat output bus, with register k on bits 8k+7 down to 8k. Every register resets to zero.

The protocol engine is one state machine. Any START moves it to ADDR, and any STOP moves it to IDLE. The other transitions happen on a synchronized SCL falling edge:
- ADDR goes to AACK on an address match and to SKIP otherwise.
- AACK goes to RDAT when the direction bit is read and to SUB when it is write.
- SUB goes to SACK after eight bits, and SACK goes to WDAT.
- WDAT goes to WACK after eight bits, and WACK goes back to WDAT.
- RDAT goes to RACK after the eighth bit, and RACK goes to SKIP.
- IDLE and SKIP leave only on START or STOP.

Top module: `avsw_ctrl_slave`

## Requirements
- R1: The 7-bit device address is 0x4B. Address byte 0x96 (write) and address byte 0x97 (read) are acknowledged by pulling SDA low during the ninth clock.
- R2: In a write, the first byte after the address is the register pointer. The next byte is stored in that register, and register k appears on regs_flat[8k+7:8k].
- R3: Each further data byte before STOP is stored at the next pointer value: pointer+1, pointer+2, and so on.
- R4: A read sends no pointer byte. The slave returns status_in, most significant bit first, as captured at the falling edge that ends the address acknowledge.
- R5: status_clr is a single-cycle pulse, issued exactly once per read, when the eighth status bit completes. Writes never raise it.
- R6: After reset, all seven registers are 0x00, sda_oe is low and status_clr is low.
- R7: Data bytes aimed at a pointer above 0x06 are acknowledged but discarded. The pointer saturates at 0xFF and never wraps back into 0x00 to 0x06.
- R8: After any non-matching address byte, the slave drives nothing and stores nothing until the next START.
- R9: sda_oe changes only while the synchronized SCL is low. It is asserted only for acknowledge bits and for zero bits of read data.
- R10: A START at any point, including in the middle of a byte, restarts address reception. A STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as sensed at the pad |
| sda_in | input | 1 | Serial data line as sensed at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| status_in | input | 8 | Status byte from the monitor block |
| status_clr | output | 1 | One-cycle strobe after the status byte is read |
| regs_flat | output | NREG*8 | All control registers, register k at bits 8k+7:8k |

## Verification
The embedded assertions check the following on every clock:
- sda_oe changes only while the synchronized clock is low.
- The register bank changes only in the cycle that enters WACK.
- A write aimed beyond the bank leaves the bank unchanged.
- Once the pointer is past the bank, it stays past the bank.
- The clear strobe lasts one cycle and is followed by RACK.
- Every START zeroes the bit count.

The following are shown only by the bench's bus scenarios:
- Which address bytes are acknowledged.
- That the right byte lands in the right register under auto-increment.
- That the status value is shifted out correctly.
- That an aborted byte followed by a fresh START leaves earlier registers untouched.

// File: rtl/avsw_ctrl_pkg.sv
package avsw_ctrl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_SUB,
        ST_SACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } bus_state_e;
endpackage

// File: rtl/avsw_bus_sync.sv
module avsw_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_bit,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES;

    // STAGES flops of synchronizer plus one history flop for edge detection
    logic [LAST:0] scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[LAST-1:0], scl_in};
            sda_q <= {sda_q[LAST-1:0], sda_in};
        end
    end

    logic scl_cur, scl_prv, sda_cur, sda_prv;
    assign scl_cur = scl_q[LAST-1];
    assign scl_prv = scl_q[LAST];
    assign sda_cur = sda_q[LAST-1];
    assign sda_prv = sda_q[LAST];

    assign scl_hi    = scl_cur;
    assign sda_bit   = sda_cur;
    assign scl_rise  = scl_cur & ~scl_prv;
    assign scl_fall  = ~scl_cur & scl_prv;
    assign start_det = scl_cur & scl_prv & sda_prv & ~sda_cur;
    assign stop_det  = scl_cur & scl_prv & ~sda_prv & sda_cur;
endmodule

// File: rtl/avsw_reg_bank.sv
module avsw_reg_bank #(
    parameter int NREG = 7,
    parameter int W    = 8,
    parameter int AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [W-1:0]      wdata,
    output logic [NREG*W-1:0] regs_flat
);
    localparam int FLAT_W = NREG * W;

    logic [NREG-1:0][W-1:0] bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank <= '0;
        end else if (we) begin
            for (int i = 0; i < NREG; i++) begin
                if (waddr == AW'(i)) bank[i] <= wdata;
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*W +: W] = bank[g];
    end

    // R7: a write beyond the bank leaves every register as it was
    assert_oob_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr >= AW'(NREG))) |=> $stable(regs_flat));

    logic unused_w;
    assign unused_w = ^FLAT_W;
endmodule

// File: rtl/avsw_ctrl_slave.sv
module avsw_ctrl_slave
    import avsw_ctrl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4B,
    parameter int         NREG        = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    input  logic [BYTE_W-1:0]      status_in,
    output logic                   status_clr,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    localparam int          PTR_W   = 8;
    localparam logic [3:0]  FULL    = 4'd8;
    localparam logic [3:0]  LASTOUT = 4'd7;
    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    logic scl_hi, scl_rise, scl_fall, sda_bit, start_det, stop_det;

    avsw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_hi   (scl_hi),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_bit  (sda_bit),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    bus_state_e        state, nxt;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [PTR_W-1:0]  ptr;
    logic              byte_done, wr_en;

    assign byte_done = scl_fall && (bit_cnt == FULL);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR: if (bit_cnt == FULL)
                             nxt = (shreg[7:1] == DEV_ADDR) ? ST_AACK : ST_SKIP;
                ST_AACK: nxt = shreg[0] ? ST_RDAT : ST_SUB;
                ST_SUB:  if (bit_cnt == FULL) nxt = ST_SACK;
                ST_SACK: nxt = ST_WDAT;
                ST_WDAT: if (bit_cnt == FULL) nxt = ST_WACK;
                ST_WACK: nxt = ST_WDAT;
                ST_RDAT: if (bit_cnt == LASTOUT) nxt = ST_RACK;
                ST_RACK: nxt = ST_SKIP;
                default: nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit counter, shifter and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else if (scl_rise && (state == ST_ADDR || state == ST_SUB || state == ST_WDAT)) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_bit};
            bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall) begin
            if (byte_done) bit_cnt <= '0;
            if (state == ST_SUB && byte_done) ptr <= shreg;
            if (state == ST_WDAT && byte_done && ptr != PTR_MAX) ptr <= ptr + 1'b1;
            if (state == ST_AACK) begin
                bit_cnt <= '0;
                if (shreg[0]) shreg <= status_in;
            end
            if (state == ST_RDAT) begin
                shreg   <= {shreg[BYTE_W-2:0], 1'b1};
                bit_cnt <= bit_cnt + 4'd1;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe     = 1'b0;
        status_clr = 1'b0;
        wr_en      = 1'b0;
        unique case (state)
            ST_AACK, ST_SACK, ST_WACK: sda_oe = 1'b1;
            ST_RDAT: begin
                sda_oe     = ~shreg[BYTE_W-1];
                status_clr = scl_fall && (bit_cnt == LASTOUT) && !start_det && !stop_det;
            end
            ST_WDAT: wr_en = byte_done && !start_det && !stop_det;
            default: ;
        endcase
    end

    avsw_reg_bank #(.NREG(NREG), .W(BYTE_W), .AW(PTR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .waddr    (ptr),
        .wdata    (shreg),
        .regs_flat(regs_flat)
    );

    // R9: the pad enable only moves while the synchronized clock is low
    assert_oe_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_hi);

    // R2: the register outputs only change as the data acknowledge begins
    assert_regs_on_wack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> (state == ST_WACK));

    // R5: the clear strobe is one cycle wide and closes the status byte
    assert_clr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (!status_clr && state == ST_RACK));

    // R7: a pointer past the bank never wraps back into it
    assert_ptr_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr >= PTR_W'(NREG) && state != ST_SUB) |=> (ptr >= PTR_W'(NREG)));

    // R10: every START restarts the bit count
    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bit_cnt == 4'd0));
endmodule

// File: tb/avsw_ctrl_slave_tb.sv
module avsw_ctrl_slave_tb;
    localparam int NREG = 7;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [7:0] status_in = 8'h00;
    logic sda_oe, status_clr;
    logic [NREG*8-1:0] regs_flat;
    wire  sda_bus = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    avsw_ctrl_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .status_in (status_in),
        .status_clr(status_clr),
        .regs_flat (regs_flat)
    );

    int total = 0, bad = 0, clr_cnt = 0, oe_bad = 0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [16];
    logic oe_prev = 1'b0;

    always @(posedge clk) if (rst_n && status_clr) clr_cnt <= clr_cnt + 1;

    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && m_scl) oe_bad++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] flat_model();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic b_start(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
    task automatic b_stop(); m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); endtask
    task automatic wbit(input logic b); m_sda = b; wq(); m_scl = 1; wq(); m_scl = 0; wq(); endtask
    task automatic rbit(output logic b); m_sda = 1; wq(); m_scl = 1; wq(); b = sda_bus; m_scl = 0; wq(); endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
        wbit(1'b1);
    endtask

    // write n bytes from wbuf starting at pointer sub; pointer saturates at 0xFF
    task automatic do_write(input string req, input logic [7:0] sub, input int n);
        logic ack;
        int p;
        b_start();
        wbyte(8'h96, ack); chk({req, " R1 write address ack"}, ack, 1);
        wbyte(sub, ack);   chk({req, " pointer ack"}, ack, 1);
        p = sub;
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], ack); chk({req, " data ack"}, ack, 1);
            if (p < NREG) model[p] = wbuf[i];
            if (p < 255) p++;
        end
        b_stop();
        chk({req, " bank contents"}, regs_flat, flat_model());
    endtask

    initial begin : main
        logic ack;
        logic [7:0] d;
        int c0;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R6 bank at reset", regs_flat, 0);
        chk("R6 sda_oe at reset", sda_oe, 0);
        chk("R6 status_clr at reset", status_clr, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R2: one byte into each register
        for (int k = 0; k < NREG; k++) begin
            wbuf[0] = 8'(k * 8'h11) ^ 8'hA5;
            do_write("R2 single", 8'(k), 1);
        end

        // R3: fill the bank in one transfer, then a mid-bank burst
        for (int i = 0; i < NREG; i++) wbuf[i] = 8'(i * 37 + 11);
        do_write("R3 full burst", 8'h00, NREG);
        for (int i = 0; i < 3; i++) wbuf[i] = 8'hF0 - 8'(i);
        do_write("R3 mid burst", 8'h02, 3);

        // R7: bursts running off the end, and pointers beyond the bank
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h3C + 8'(i);
        do_write("R7 overrun", 8'h05, 4);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hC3;
        do_write("R7 no wrap", 8'hFE, 4);
        do_write("R7 out of range", 8'h07, 2);

        // R4, R5: status reads over several values
        foreach (wbuf[i]) wbuf[i] = 8'h00;
        for (int v = 0; v < 6; v++) begin
            status_in = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : (v == 2) ? 8'hA5 :
                        (v == 3) ? 8'h5A : (v == 4) ? 8'h80 : 8'h01;
            c0 = clr_cnt;
            b_start();
            wbyte(8'h97, ack); chk("R1 read address ack", ack, 1);
            rbyte(d);
            b_stop();
            chk("R4 status byte", d, status_in);
            chk("R5 one clear per read", clr_cnt - c0, 1);
            chk("R4 read leaves bank", regs_flat, flat_model());
        end

        // R1, R8: sweep of address bytes around the device address
        for (int a = 8'h90; a <= 8'h9F; a++) begin
            c0 = clr_cnt;
            b_start();
            wbyte(8'(a), ack);
            chk("R1 R8 address match", ack, (a == 8'h96 || a == 8'h97) ? 1 : 0);
            if (a == 8'h97) begin
                rbyte(d);
            end else if (a == 8'h96) begin
                wbyte(8'h09, ack);
                wbyte(8'h55, ack);
            end else if (a[0]) begin
                rbyte(d);
                chk("R8 no drive after mismatch", d, 8'hFF);
            end else begin
                wbyte(8'h00, ack); chk("R8 pointer ignored", ack, 0);
                wbyte(8'hFF, ack); chk("R8 data ignored", ack, 0);
            end
            b_stop();
            chk("R8 bank untouched", regs_flat, flat_model());
            chk("R5 clear only on own read", clr_cnt - c0, (a == 8'h97) ? 1 : 0);
        end

        // R10: START in the middle of a byte, then a fresh write
        c0 = clr_cnt;
        b_start();
        wbyte(8'h96, ack);
        wbyte(8'h02, ack);
        for (int i = 0; i < 4; i++) wbit(1'b1);
        b_start();
        wbyte(8'h96, ack); chk("R10 restart address ack", ack, 1);
        wbyte(8'h03, ack);
        wbyte(8'h6E, ack);
        b_stop();
        model[3] = 8'h6E;
        chk("R10 restarted write", regs_flat, flat_model());
        chk("R5 writes raise no clear", clr_cnt - c0, 0);

        // R10: STOP right after the pointer stores nothing
        b_start();
        wbyte(8'h96, ack);
        wbyte(8'h01, ack);
        b_stop();
        chk("R10 stop after pointer", regs_flat, flat_model());

        chk("R9 pad enable moved only with clock low", oe_bad, 0);
        chk("R9 pad released at end", sda_oe, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule